// File: doc/BRIEF.md
# Register Bit-Field Move/Load Unit

This unit executes one bit-field action per command against a small file of per-packet fields and registers. A move action takes a slice of one field and writes it into a slice of another. A load action writes the low bits of a 64-bit immediate into a slice of a destination field. For a load, the slice offset and the bit count share one 16-bit control word. The bit count is stored as one less than its true value.

Each field has a fixed width, set by a parameter table. Before any write, the command is checked against these widths. A command that does not fit is rejected with a bad-argument flag, and nothing is written. One field is the VLAN tag control word. When a result is written to that field, the unit also signals whether the 802.1Q header is to be removed, or added or changed. The choice depends on the CFI bit of the result.

The surrounding pipeline presents the current field values with the command. It applies the returned destination value and the tag side effect.

Top module: `bfmu_top`

## Requirements
- R1: A move (cmd_op=0) copies source bits [src_ofs, src_ofs+n) into destination bits [dst_ofs, dst_ofs+n), where n is cmd_nbits, bit 0 is the least significant bit and each upper bound is exclusive.
- R2: For a load (cmd_op=1), the slice offset is taken from cmd_ofs_nbits[15:6] and the bit count is cmd_ofs_nbits[5:0] plus one, so the count can be 1 to 64.
- R3: A load writes immediate bits [0, n) into destination bits [ofs, ofs+n).
- R4: A command is rejected (err=1, wr_en=0) when offset plus bit count exceeds the width of the destination field. A move is also rejected when src_ofs plus n exceeds the width of the source field. The field widths are 16, 48, 16, 8, 32, 64, 32 and 32 bits for selectors 0 to 7.
- R5: A load is rejected when any immediate bit at position n or above is set.
- R6: A move with cmd_nbits equal to 0 or greater than 64 is rejected.
- R7: Destination bits outside the written slice keep the value they had on field_vals.
- R8: When an accepted command writes field 2 (the VLAN tag control word) and bit 12 (CFI) of the result is 0, vlan_strip=1, vlan_push=0 and vlan_tci=0.
- R9: When an accepted command writes field 2 and bit 12 of the result is 1, vlan_push=1, vlan_strip=0 and vlan_tci equals result[15:0] with bit 12 cleared.
- R10: All outputs are 0 after reset. Done is high for exactly the cycle after each command is accepted. Err and wr_en are high only together with done, and at most one of the two is high.
- R11: An accepted command to any destination other than field 2 leaves vlan_push and vlan_strip low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = move, 1 = load |
| cmd_src_sel | input | 3 | Source field selector (move) |
| cmd_dst_sel | input | 3 | Destination field selector |
| cmd_src_ofs | input | 16 | Source slice offset (move) |
| cmd_dst_ofs | input | 16 | Destination slice offset (move) |
| cmd_nbits | input | 16 | Bit count (move) |
| cmd_ofs_nbits | input | 16 | Packed offset and count minus one (load) |
| cmd_imm | input | 64 | Immediate value (load) |
| field_vals | input | 512 | Current field values, field i at bits [64i+63:64i] |
| done | output | 1 | Command finished |
| err | output | 1 | Bad-argument rejection |
| wr_en | output | 1 | Write wr_data to field wr_sel |
| wr_sel | output | 3 | Destination field of the write |
| wr_data | output | 64 | Updated destination value |
| vlan_push | output | 1 | Add or modify the 802.1Q header |
| vlan_strip | output | 1 | Remove the 802.1Q header |
| vlan_tci | output | 16 | New tag control value with CFI cleared |

## Verification
The bench targets the range limits at exact fit and one bit past them, on both the source and the destination side. A design with an off-by-one sum check would either reject a command that fits or write past the field. It tests a 64-bit load with a packed count of 63. A decoder that forgets the plus-one, or a mask that overflows at 64, produces a wrong or empty write. It tests immediates with a stray bit just above the count, and move counts of 0 and 65, which a lax checker would accept. On the VLAN field it writes results with CFI set and with CFI cleared, including a single-bit load that clears only CFI. This catches inverted side effects, a tag value that keeps the CFI bit, and a merge that disturbs the bits around the slice.

// File: rtl/bfmu_pkg.sv
package bfmu_pkg;
  localparam int DW    = 64;
  localparam int CNT_W = 7;

  typedef enum logic {
    OP_MOVE = 1'b0,
    OP_LOAD = 1'b1
  } bf_op_e;

  // ones in bits [0, n); n of 64 or more gives all ones
  function automatic logic [DW-1:0] low_mask(input logic [CNT_W-1:0] n);
    logic [DW-1:0] m;
    if (n >= CNT_W'(DW)) m = '1;
    else                 m = (64'd1 << n) - 64'd1;
    return m;
  endfunction
endpackage

// File: rtl/bfmu_range_chk.sv
module bfmu_range_chk
  import bfmu_pkg::*;
#(
  parameter int                       NUM_FIELDS   = 8,
  parameter int                       SEL_W        = 3,
  parameter logic [NUM_FIELDS*7-1:0]  FIELD_WIDTHS = '0
) (
  input  bf_op_e           op,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [SEL_W-1:0] dst_sel,
  input  logic [15:0]      src_ofs,
  input  logic [15:0]      dst_ofs,
  input  logic [15:0]      nbits_mv,
  input  logic [15:0]      ofs_nbits,
  input  logic [DW-1:0]    imm,
  output logic             bad,
  output logic [5:0]       eff_src_ofs,
  output logic [5:0]       eff_dst_ofs,
  output logic [CNT_W-1:0] eff_n
);
  logic [6:0] w_tab [NUM_FIELDS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_wtab
      assign w_tab[gi] = FIELD_WIDTHS[gi*7 +: 7];
    end
  endgenerate

  logic [15:0] n16, dofs16;
  logic [16:0] src_end, dst_end;
  logic [6:0]  src_w, dst_w;
  logic        sel_bad, n_bad, src_bad, dst_bad, imm_bad;

  always_comb begin
    if (op == OP_LOAD) begin
      n16    = {10'd0, ofs_nbits[5:0]} + 16'd1;
      dofs16 = {6'd0, ofs_nbits[15:6]};
    end else begin
      n16    = nbits_mv;
      dofs16 = dst_ofs;
    end
    sel_bad = (32'(src_sel) >= NUM_FIELDS && op == OP_MOVE) ||
              (32'(dst_sel) >= NUM_FIELDS);
    src_w   = sel_bad ? 7'd0 : w_tab[src_sel];
    dst_w   = sel_bad ? 7'd0 : w_tab[dst_sel];
    n_bad   = (n16 == 16'd0) || (n16 > 16'd64);
    src_end = {1'b0, src_ofs} + {1'b0, n16};
    dst_end = {1'b0, dofs16}  + {1'b0, n16};
    src_bad = (op == OP_MOVE) && (src_end > {10'd0, src_w});
    dst_bad = dst_end > {10'd0, dst_w};
    eff_n   = n16[CNT_W-1:0];
    imm_bad = (op == OP_LOAD) && ((imm & ~low_mask(eff_n)) != '0);
    bad     = sel_bad | n_bad | src_bad | dst_bad | imm_bad;
    eff_src_ofs = src_ofs[5:0];
    eff_dst_ofs = dofs16[5:0];
  end
endmodule

// File: rtl/bfmu_merge.sv
module bfmu_merge
  import bfmu_pkg::*;
(
  input  bf_op_e           op,
  input  logic [DW-1:0]    src_val,
  input  logic [DW-1:0]    dst_val,
  input  logic [DW-1:0]    imm,
  input  logic [5:0]       src_ofs,
  input  logic [5:0]       dst_ofs,
  input  logic [CNT_W-1:0] n,
  output logic [DW-1:0]    result
);
  logic [DW-1:0] m, slice, wmask;

  always_comb begin
    m      = low_mask(n);
    slice  = ((op == OP_LOAD) ? imm : (src_val >> src_ofs)) & m;
    wmask  = m << dst_ofs;
    result = (dst_val & ~wmask) | (slice << dst_ofs);
  end
endmodule

// File: rtl/bfmu_top.sv
module bfmu_top
  import bfmu_pkg::*;
#(
  parameter int                       NUM_FIELDS   = 8,
  parameter int                       SEL_W        = $clog2(NUM_FIELDS),
  parameter logic [NUM_FIELDS*7-1:0]  FIELD_WIDTHS = {7'd32, 7'd32, 7'd64, 7'd32,
                                                     7'd8,  7'd16, 7'd48, 7'd16},
  parameter int                       VLAN_SEL     = 2,
  parameter int                       CFI_BIT      = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_op,
  input  logic [SEL_W-1:0]         cmd_src_sel,
  input  logic [SEL_W-1:0]         cmd_dst_sel,
  input  logic [15:0]              cmd_src_ofs,
  input  logic [15:0]              cmd_dst_ofs,
  input  logic [15:0]              cmd_nbits,
  input  logic [15:0]              cmd_ofs_nbits,
  input  logic [63:0]              cmd_imm,
  input  logic [NUM_FIELDS*64-1:0] field_vals,
  output logic                     done,
  output logic                     err,
  output logic                     wr_en,
  output logic [SEL_W-1:0]         wr_sel,
  output logic [63:0]              wr_data,
  output logic                     vlan_push,
  output logic                     vlan_strip,
  output logic [15:0]              vlan_tci
);
  logic [DW-1:0] fv [NUM_FIELDS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_unpack
      assign fv[gi] = field_vals[gi*DW +: DW];
    end
  endgenerate

  bf_op_e           op;
  logic             bad;
  logic [5:0]       s_ofs, d_ofs;
  logic [CNT_W-1:0] n_eff;
  logic [DW-1:0]    src_val, dst_val, result;

  assign op      = bf_op_e'(cmd_op);
  assign src_val = (32'(cmd_src_sel) < NUM_FIELDS) ? fv[cmd_src_sel] : '0;
  assign dst_val = (32'(cmd_dst_sel) < NUM_FIELDS) ? fv[cmd_dst_sel] : '0;

  bfmu_range_chk #(
    .NUM_FIELDS  (NUM_FIELDS),
    .SEL_W       (SEL_W),
    .FIELD_WIDTHS(FIELD_WIDTHS)
  ) u_chk (
    .op         (op),
    .src_sel    (cmd_src_sel),
    .dst_sel    (cmd_dst_sel),
    .src_ofs    (cmd_src_ofs),
    .dst_ofs    (cmd_dst_ofs),
    .nbits_mv   (cmd_nbits),
    .ofs_nbits  (cmd_ofs_nbits),
    .imm        (cmd_imm),
    .bad        (bad),
    .eff_src_ofs(s_ofs),
    .eff_dst_ofs(d_ofs),
    .eff_n      (n_eff)
  );

  bfmu_merge u_merge (
    .op     (op),
    .src_val(src_val),
    .dst_val(dst_val),
    .imm    (cmd_imm),
    .src_ofs(s_ofs),
    .dst_ofs(d_ofs),
    .n      (n_eff),
    .result (result)
  );

  // next-state
  logic             accept, is_vlan;
  logic             done_d, err_d, wr_en_d, push_d, strip_d;
  logic [15:0]      tci_d;
  logic             data_en;

  always_comb begin
    accept  = cmd_valid && !bad;
    is_vlan = (32'(cmd_dst_sel) == VLAN_SEL);
    done_d  = cmd_valid;
    err_d   = cmd_valid && bad;
    wr_en_d = accept;
    data_en = accept;
    push_d  = accept && is_vlan && result[CFI_BIT];
    strip_d = accept && is_vlan && !result[CFI_BIT];
    tci_d   = push_d ? (result[15:0] & ~(16'd1 << CFI_BIT)) : 16'd0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      err        <= 1'b0;
      wr_en      <= 1'b0;
      vlan_push  <= 1'b0;
      vlan_strip <= 1'b0;
      vlan_tci   <= '0;
    end else begin
      done       <= done_d;
      err        <= err_d;
      wr_en      <= wr_en_d;
      vlan_push  <= push_d;
      vlan_strip <= strip_d;
      vlan_tci   <= tci_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel  <= '0;
      wr_data <= '0;
    end else if (data_en) begin
      wr_sel  <= cmd_dst_sel;
      wr_data <= result;
    end
  end

  // assertions
  p_no_write_on_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en);
  p_flags_need_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err || wr_en) |-> done);
  p_tag_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vlan_push, vlan_strip}));
  p_strip_tci_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vlan_strip |-> (vlan_tci == 16'd0));
  p_push_cfi_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vlan_push |-> (!vlan_tci[CFI_BIT] && wr_data[CFI_BIT]));
  p_tag_only_vlan_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vlan_push || vlan_strip) |-> (wr_en && 32'(wr_sel) == VLAN_SEL));
endmodule

// File: tb/bfmu_top_test.sv
module bfmu_top_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_op;
  logic [2:0]   cmd_src_sel, cmd_dst_sel;
  logic [15:0]  cmd_src_ofs, cmd_dst_ofs, cmd_nbits, cmd_ofs_nbits;
  logic [63:0]  cmd_imm;
  logic [511:0] field_vals;
  logic         done, err, wr_en, vlan_push, vlan_strip;
  logic [2:0]   wr_sel;
  logic [63:0]  wr_data;
  logic [15:0]  vlan_tci;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] fv [8];
  localparam int FW [8] = '{16, 48, 16, 8, 32, 64, 32, 32};

  always #4 clk = ~clk;

  bfmu_top uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src_sel(cmd_src_sel), .cmd_dst_sel(cmd_dst_sel),
    .cmd_src_ofs(cmd_src_ofs), .cmd_dst_ofs(cmd_dst_ofs),
    .cmd_nbits(cmd_nbits), .cmd_ofs_nbits(cmd_ofs_nbits), .cmd_imm(cmd_imm),
    .field_vals(field_vals), .done(done), .err(err), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .vlan_push(vlan_push),
    .vlan_strip(vlan_strip), .vlan_tci(vlan_tci)
  );

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [63:0] mk(input int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pack_fields();
    for (int i = 0; i < 8; i++) field_vals[i*64 +: 64] = fv[i];
  endtask

  // expected behaviour from the requirements
  task automatic expect_cmd(output logic e_err, output logic [63:0] e_data,
                            output logic e_push, output logic e_strip,
                            output logic [15:0] e_tci);
    int n, so, dof;
    logic [63:0] slice;
    if (cmd_op) begin
      n   = int'(cmd_ofs_nbits[5:0]) + 1;
      dof = int'(cmd_ofs_nbits[15:6]);
      so  = 0;
    end else begin
      n   = int'(cmd_nbits);
      dof = int'(cmd_dst_ofs);
      so  = int'(cmd_src_ofs);
    end
    e_err = 1'b0;
    if (n < 1 || n > 64) e_err = 1'b1;
    if (dof + n > FW[cmd_dst_sel]) e_err = 1'b1;
    if (!cmd_op && so + n > FW[cmd_src_sel]) e_err = 1'b1;
    if (cmd_op && ((cmd_imm & ~mk(n)) != 0)) e_err = 1'b1;
    e_data = 0; e_push = 0; e_strip = 0; e_tci = 0;
    if (!e_err) begin
      slice  = cmd_op ? cmd_imm : (fv[cmd_src_sel] >> so);
      slice  = slice & mk(n);
      e_data = (fv[cmd_dst_sel] & ~(mk(n) << dof)) | (slice << dof);
      if (cmd_dst_sel == 3'd2) begin
        e_push  = e_data[12];
        e_strip = !e_data[12];
        e_tci   = e_data[12] ? (e_data[15:0] & 16'hEFFF) : 16'h0;
      end
    end
  endtask

  task automatic run(input string tag);
    logic e_err, e_push, e_strip;
    logic [63:0] e_data;
    logic [15:0] e_tci;
    pack_fields();
    expect_cmd(e_err, e_data, e_push, e_strip, e_tci);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " R10 done"}, {63'd0, done}, 64'd1);
    chk({tag, " R4 err"}, {63'd0, err}, {63'd0, e_err});
    chk({tag, " R10 wr_en"}, {63'd0, wr_en}, {63'd0, !e_err});
    chk({tag, " R11 tag flags"}, {62'd0, vlan_push, vlan_strip}, {62'd0, e_push, e_strip});
    if (!e_err) begin
      chk({tag, " R1 data"}, wr_data, e_data);
      chk({tag, " sel"}, {61'd0, wr_sel}, {61'd0, cmd_dst_sel});
      chk({tag, " R9 tci"}, {48'd0, vlan_tci}, {48'd0, e_tci});
    end
  endtask

  task automatic mv(input int s, input int so, input int d, input int dof, input int n);
    cmd_op = 1'b0; cmd_src_sel = 3'(s); cmd_dst_sel = 3'(d);
    cmd_src_ofs = 16'(so); cmd_dst_ofs = 16'(dof); cmd_nbits = 16'(n);
  endtask

  task automatic ld(input int d, input int ofs, input int n, input logic [63:0] imm);
    cmd_op = 1'b1; cmd_dst_sel = 3'(d);
    cmd_ofs_nbits = {10'(ofs), 6'(n - 1)}; cmd_imm = imm;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_src_sel = 0; cmd_dst_sel = 0;
    cmd_src_ofs = 0; cmd_dst_ofs = 0; cmd_nbits = 0; cmd_ofs_nbits = 0; cmd_imm = 0;
    for (int i = 0; i < 8; i++) fv[i] = 0;
    pack_fields();
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {done, err, wr_en, vlan_push, vlan_strip, 3'd0} | {56'd0, wr_data[7:0]} | {48'd0, vlan_tci},
        64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    fv[5] = 64'h0123456789ABCDEF; fv[4] = 64'hFFFFFFFF;
    mv(5, 8, 4, 4, 16);
    run("R1 R7 move mid-slice");
    chk("R7 move result", wr_data, 64'hFFFABCDF);

    fv[7] = 64'h11223344;
    ld(7, 8, 8, 64'h5A);
    run("R2 R3 load byte");
    chk("R3 load result", wr_data, 64'h11225A44);

    ld(5, 0, 64, 64'hDEADBEEFCAFEF00D);
    run("R2 load 64 bits");
    chk("R2 full-width load", wr_data, 64'hDEADBEEFCAFEF00D);

    ld(6, 16, 16, 64'h1234);
    run("R4 load exact fit");
    ld(6, 16, 17, 64'h1234);
    run("R4 load one past dst");
    mv(0, 10, 7, 0, 7);
    run("R4 move one past src");
    mv(0, 9, 7, 0, 7);
    run("R4 move src exact fit");

    ld(7, 0, 4, 64'h10);
    run("R5 imm stray bit");
    ld(5, 0, 63, 64'h8000000000000000);
    run("R5 imm top bit");

    mv(5, 0, 5, 0, 0);
    run("R6 move zero count");
    mv(5, 0, 5, 0, 65);
    run("R6 move count 65");

    fv[2] = 64'hF064;
    ld(2, 0, 16, 64'h0123);
    run("R8 vlan strip");
    chk("R8 strip flag", {62'd0, vlan_push, vlan_strip}, 64'd1);
    ld(2, 0, 16, 64'h3064);
    run("R9 vlan push");
    chk("R9 push tci", {48'd0, vlan_tci}, 64'h2064);
    fv[2] = 64'h3064;
    ld(2, 12, 1, 64'h0);
    run("R8 R7 clear cfi only");
    chk("R7 vlan neighbours", wr_data, 64'h2064);

    @(negedge clk);
    chk("R10 idle done low", {63'd0, done}, 64'd0);

    for (int k = 0; k < 400; k++) begin
      int wd, ws, n, lim;
      for (int i = 0; i < 8; i++) fv[i] = {$urandom, $urandom} & mk(FW[i]);
      cmd_src_sel = 3'($urandom % 8); cmd_dst_sel = 3'($urandom % 8);
      ws = FW[cmd_src_sel]; wd = FW[cmd_dst_sel];
      cmd_op = 1'($urandom % 2);
      if ($urandom % 6 == 0) begin
        cmd_nbits = 16'($urandom % 71); cmd_src_ofs = 16'($urandom % 71);
        cmd_dst_ofs = 16'($urandom % 71); cmd_ofs_nbits = 16'($urandom);
        cmd_imm = {$urandom, $urandom};
      end else if (cmd_op) begin
        n = 1 + int'($urandom % wd);
        ld(int'(cmd_dst_sel), int'($urandom % (wd - n + 1)), n,
           {$urandom, $urandom} & mk(n));
      end else begin
        lim = (ws < wd) ? ws : wd;
        n = 1 + int'($urandom % lim);
        mv(int'(cmd_src_sel), int'($urandom % (ws - n + 1)), int'(cmd_dst_sel),
           int'($urandom % (wd - n + 1)), n);
      end
      run("R1 R3 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule